// File: doc/BRIEF.md
# Framing Byte Aligner

This block sits behind a deserializer that delivers 32-bit words with no relation to byte boundaries. It finds a framing sequence in the received bit stream. The sequence is two words of repeated framing byte one, followed by two words of repeated framing byte two. From where the sequence sits, the block sets a barrel-shift selector so that the words it emits fall on byte boundaries. To do this it joins the previous raw word and the current raw word into a 64-bit window, and checks every one of the 32 possible bit positions in parallel each cycle.

Two enable inputs control when the selector may move. The byte-only enable corrects just the bit phase inside a byte. The frame enable does that and also moves the selector to the exact word position of the framing transition. When both enables are low, the selector holds its position, even if the pattern shows up again at another position. A one-cycle detect pulse reports every framing transition it finds. A one-cycle realign pulse reports every move of the selector.

Top module: `frame_byte_aligner`

## Requirements
- R1: While reset is asserted, and until the internal reset has left on the second rising edge after release, the selector offset is 0 and the aligned word, the detect pulse and the realign pulse are all 0.
- R2: Take offset k and the 64-bit window {previous raw word, current raw word}, MSB first. The aligned word is the 32 bits that start k bits below the window MSB. It is registered on the third rising edge after the edge that samples the later raw word.
- R3: A transition is found at offset k when the 32 bits at offset k equal 0x6F6F6F6F in one window and 0x14141414 in the next. On each transition the detect pulse is high for exactly one cycle, the cycle after the second window, whatever the enables are.
- R4: With the frame enable high, a transition at offset k sets the offset to k. The first framing-byte-one word of the sequence is then the first correctly aligned output word, followed by the rest of the sequence and the data after it.
- R5: With either enable high, a window whose 32 bits at offset k equal 0x6F6F6F6F, where k mod 8 differs from the current offset mod 8, replaces the low three offset bits with k mod 8. The upper two offset bits are kept.
- R6: With both enables low, the offset never changes, even when the sequence arrives at another offset. The detect pulse still fires.
- R7: The realign pulse is high for exactly one cycle, and only in the first cycle in which a changed offset is in effect. It can coincide with the detect pulse.
- R8: With only the byte-only enable high, the two upper offset bits, which hold the word position, never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 32 | Raw deserialized word, earliest bit in the MSB |
| en_byte_only | input | 1 | Allows bit-phase correction only |
| en_frame_lock | input | 1 | Allows bit-phase correction and word-position lock |
| al_word | output | 32 | Aligned output word |
| frame_det_pulse | output | 1 | One-cycle pulse per framing transition found |
| realign_pulse | output | 1 | One-cycle pulse per selector move |

## Verification
The detect pulse and the realign pulse fall in the same cycle when a frame-enabled transition moves the upper, word-position offset bits. The bench provokes this by sending the sequence at offsets such as 13, 31 and 16. There the byte-phase correction has already fixed the low bits two cycles earlier, so the remaining move is a word move made by the transition. The judgement checks that both pulses are high in that single cycle and that each is high nowhere else in the scenario. It also checks the case with no move, where detect fires alone.

// File: rtl/fba_pkg.sv
package fba_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PH_W   = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] SYNC_ONE_BYTE = 8'h6F;
  localparam logic [BYTE_W-1:0] SYNC_TWO_BYTE = 8'h14;

  typedef enum logic [1:0] {
    DEC_HOLD  = 2'd0,
    DEC_PHASE = 2'd1,
    DEC_FRAME = 2'd2
  } fba_dec_e;

endpackage

// File: rtl/fba_rst_sync.sv
module fba_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/fba_search.sv
module fba_search
  import fba_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*W-1:0] win,
  output logic [W-1:0]   one_hit,
  output logic [W-1:0]   frame_hit
);

  localparam int unsigned NB = W / BYTE_W;
  localparam logic [W-1:0] ONE_WORD = {NB{SYNC_ONE_BYTE}};
  localparam logic [W-1:0] TWO_WORD = {NB{SYNC_TWO_BYTE}};

  logic [W-1:0] two_hit;
  logic [W-1:0] one_hit_q;
  logic [W-1:0] one_hit_d;

  // One comparator pair per bit offset of the window
  for (genvar k = 0; k < W; k++) begin : g_off
    logic [W-1:0] cand;
    assign cand       = win[2*W-1-k -: W];
    assign one_hit[k] = (cand == ONE_WORD);
    assign two_hit[k] = (cand == TWO_WORD);
  end

  always_comb begin
    one_hit_d = one_hit;
    frame_hit = two_hit & one_hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_hit_q <= '0;
    end else begin
      one_hit_q <= one_hit_d;
    end
  end

endmodule

// File: rtl/fba_ctl.sv
module fba_ctl
  import fba_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned OFF_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_phase,
  input  logic             en_frame,
  input  logic [W-1:0]     one_hit,
  input  logic [W-1:0]     frame_hit,
  output logic [OFF_W-1:0] off_q,
  output logic             det_q,
  output logic             rl_q
);

  logic [W-1:0]     phase_miss;
  logic [OFF_W-1:0] frame_k;
  logic [OFF_W-1:0] phase_k;
  logic [OFF_W-1:0] off_d;
  logic             off_ce;
  logic             det_d;
  logic             rl_d;
  fba_dec_e         dec;

  function automatic logic [OFF_W-1:0] lowest_set(input logic [W-1:0] v);
    logic [OFF_W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) r = OFF_W'(i);
    end
    return r;
  endfunction

  // Offsets whose bit phase disagrees with the current selector
  for (genvar k = 0; k < W; k++) begin : g_phase
    localparam logic [OFF_W-1:0] KV = OFF_W'(k);
    assign phase_miss[k] = one_hit[k] && (KV[PH_W-1:0] != off_q[PH_W-1:0]);
  end

  always_comb begin
    frame_k = lowest_set(frame_hit);
    phase_k = lowest_set(phase_miss);
    dec     = DEC_HOLD;
    if (en_frame && (|frame_hit)) begin
      dec = DEC_FRAME;
    end else if ((en_frame || en_phase) && (|phase_miss)) begin
      dec = DEC_PHASE;
    end
    case (dec)
      DEC_FRAME: off_d = frame_k;
      DEC_PHASE: off_d = {off_q[OFF_W-1:PH_W], phase_k[PH_W-1:0]};
      default:   off_d = off_q;
    endcase
    off_ce = (dec != DEC_HOLD);
    det_d  = |frame_hit;
    rl_d   = (off_d != off_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_ce) begin
      off_q <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      rl_q  <= 1'b0;
    end else begin
      det_q <= det_d;
      rl_q  <= rl_d;
    end
  end

endmodule

// File: rtl/fba_shift.sv
module fba_shift #(
  parameter int unsigned W     = 32,
  parameter int unsigned OFF_W = $clog2(W),
  parameter int unsigned LAG   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*W-1:0]   win,
  input  logic [OFF_W-1:0] off,
  output logic [W-1:0]     out_q
);

  logic [2*W-1:0] stage_q [LAG];
  logic [2*W-1:0] shifted;
  logic [W-1:0]   out_d;

  // Window delay line, so the selector update lands before the data
  for (genvar s = 0; s < LAG; s++) begin : g_lag
    logic [2*W-1:0] src;
    if (s == 0) begin : g_head
      assign src = win;
    end else begin : g_body
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= src;
      end
    end
  end

  always_comb begin
    shifted = stage_q[LAG-1] << off;
    out_d   = shifted[2*W-1 -: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/frame_byte_aligner.sv
module frame_byte_aligner #(
  parameter int unsigned W   = 32,
  parameter int unsigned LAG = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_word,
  input  logic         en_byte_only,
  input  logic         en_frame_lock,
  output logic [W-1:0] al_word,
  output logic         frame_det_pulse,
  output logic         realign_pulse
);

  localparam int unsigned OFF_W = $clog2(W);

  logic           rst_sync_n;
  logic [W-1:0]   prev_q;
  logic [W-1:0]   prev_d;
  logic [2*W-1:0] win;
  logic [W-1:0]   one_hit;
  logic [W-1:0]   frame_hit;
  logic [OFF_W-1:0] off_q;

  fba_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  always_comb begin
    prev_d = rx_word;
    win    = {prev_q, rx_word};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  fba_search #(.W(W)) u_search (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .win       (win),
    .one_hit   (one_hit),
    .frame_hit (frame_hit)
  );

  fba_ctl #(.W(W), .OFF_W(OFF_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_phase  (en_byte_only),
    .en_frame  (en_frame_lock),
    .one_hit   (one_hit),
    .frame_hit (frame_hit),
    .off_q     (off_q),
    .det_q     (frame_det_pulse),
    .rl_q      (realign_pulse)
  );

  fba_shift #(.W(W), .OFF_W(OFF_W), .LAG(LAG)) u_shift (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .win   (win),
    .off   (off_q),
    .out_q (al_word)
  );

endmodule

// File: rtl/fba_checker.sv
module fba_checker #(
  parameter int unsigned OFF_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_byte,
  input logic             en_frame,
  input logic [OFF_W-1:0] off_q,
  input logic             det,
  input logic             rl
);

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_byte && !en_frame) |=> $stable(off_q));

  // R8
  phase_only_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_byte && !en_frame) |=> (off_q[OFF_W-1:3] == $past(off_q[OFF_W-1:3])));

  // R7
  realign_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rl |-> (off_q != $past(off_q)));

  // R7
  move_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_q) |-> rl);

  // R7
  realign_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rl |-> $past(en_byte || en_frame));

  // R3
  detect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> !det);

endmodule

bind frame_byte_aligner fba_checker #(.OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en_byte  (en_byte_only),
  .en_frame (en_frame_lock),
  .off_q    (off_q),
  .det      (frame_det_pulse),
  .rl       (realign_pulse)
);

// File: tb/frame_byte_aligner_bench.sv
module frame_byte_aligner_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSTEP      = 512;
  localparam int NSCN       = 11;

  // {shift[4:0], en_byte, en_frame, expected offset[4:0], expected realign count[1:0]}
  localparam logic [13:0] SCN_TBL [10] = '{
    {5'd0,  1'b0, 1'b1, 5'd0,  2'd0},
    {5'd13, 1'b0, 1'b1, 5'd13, 2'd2},
    {5'd21, 1'b1, 1'b0, 5'd13, 2'd0},
    {5'd6,  1'b1, 1'b0, 5'd14, 2'd1},
    {5'd27, 1'b0, 1'b0, 5'd14, 2'd0},
    {5'd3,  1'b0, 1'b0, 5'd14, 2'd0},
    {5'd31, 1'b0, 1'b1, 5'd31, 2'd2},
    {5'd31, 1'b0, 1'b1, 5'd31, 2'd0},
    {5'd16, 1'b1, 1'b1, 5'd16, 2'd2},
    {5'd9,  1'b0, 1'b0, 5'd16, 2'd0}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] rx_word;
  logic        en_byte_only;
  logic        en_frame_lock;
  logic [31:0] al_word;
  logic        frame_det_pulse;
  logic        realign_pulse;

  frame_byte_aligner u_frame_byte_aligner (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_word         (rx_word),
    .en_byte_only    (en_byte_only),
    .en_frame_lock   (en_frame_lock),
    .al_word         (al_word),
    .frame_det_pulse (frame_det_pulse),
    .realign_pulse   (realign_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int          total;
  int          bad;
  int          n;
  bit          done;
  logic [31:0] raw   [NSTEP];
  logic [31:0] out_s [NSTEP];
  logic        det_s [NSTEP];
  logic        rl_s  [NSTEP];
  int          sc_base [NSCN];
  logic [13:0] sc_cfg  [NSCN];

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] lword(input int i);
    if (i == 5 || i == 6) return 32'h6F6F_6F6F;
    if (i == 7 || i == 8) return 32'h1414_1414;
    if (i == 9)  return 32'h0123_4567;
    if (i == 10) return 32'h89AB_CDEF;
    if (i == 11) return 32'h3C5A_96E1;
    if (i == 12) return 32'h2B4D_F078;
    return 32'h0;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] a, input logic [31:0] b,
                                       input int k);
    logic [63:0] t;
    t = {a, b} << k;
    return t[63:32];
  endfunction

  task automatic step(input logic [31:0] w);
    @(negedge clk);
    out_s[n] = al_word;
    det_s[n] = frame_det_pulse;
    rl_s[n]  = realign_pulse;
    raw[n]   = w;
    rx_word  = w;
    n++;
  endtask

  task automatic run_scn(input logic [13:0] cfg, input int idx);
    int s;
    logic [63:0] t;
    s = int'(cfg[13:9]);
    en_byte_only  = cfg[8];
    en_frame_lock = cfg[7];
    sc_base[idx]  = n;
    sc_cfg[idx]   = cfg;
    for (int i = 0; i < 14; i++) begin
      t = {(i == 0) ? 32'h0 : lword(i - 1), lword(i)} >> s;
      step(t[31:0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_word = '0;
    repeat (2) @(negedge clk);
    // R1: reset state at the ports
    chk(al_word == 32'h0, "R1 word in reset", al_word, 32'h0);
    chk(frame_det_pulse == 1'b0, "R1 detect in reset", {31'h0, frame_det_pulse}, 32'h0);
    chk(realign_pulse == 1'b0, "R1 realign in reset", {31'h0, realign_pulse}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic eval_scn(input int idx);
    int b, dcnt, rcnt;
    logic [4:0] eoff;
    logic [31:0] exp;
    b    = sc_base[idx];
    eoff = sc_cfg[idx][6:2];
    dcnt = 0;
    rcnt = 0;
    for (int i = b + 1; i <= b + 14; i++) begin
      dcnt += int'(det_s[i]);
      rcnt += int'(rl_s[i]);
    end
    // R3: one detect pulse, one cycle after the first A2 window
    chk(dcnt == 1, $sformatf("R3 scn%0d detect count", idx), dcnt, 1);
    chk(det_s[b + 9] == 1'b1, $sformatf("R3 scn%0d detect timing", idx),
        {31'h0, det_s[b + 9]}, 32'h1);
    // R7 / R5: number of selector moves
    chk(rcnt == int'(sc_cfg[idx][1:0]), $sformatf("R7 R5 scn%0d realign count", idx),
        rcnt, {30'h0, sc_cfg[idx][1:0]});
    if (sc_cfg[idx][7]) begin
      // R7: coincidence with detect exactly when a word move is left to do
      chk(rl_s[b + 9] == (sc_cfg[idx][1:0] == 2'd2), $sformatf("R7 scn%0d coincidence", idx),
          {31'h0, rl_s[b + 9]}, {31'h0, sc_cfg[idx][1:0] == 2'd2});
      for (int i = 0; i < 8; i++) begin
        exp = lword(5 + i);
        // R4: framed sequence emerges aligned
        chk(out_s[b + 10 + i] == exp, $sformatf("R4 scn%0d word%0d", idx, i),
            out_s[b + 10 + i], exp);
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        exp = pick(raw[b + 5 + i], raw[b + 6 + i], int'(eoff));
        // R2 with R5/R6/R8: output follows the held or phase-fixed offset
        chk(out_s[b + 10 + i] == exp,
            $sformatf("R2 R6 R8 scn%0d word%0d", idx, i), out_s[b + 10 + i], exp);
      end
    end
  endtask

  initial begin
    total = 0;
    bad = 0;
    n = 0;
    done = 1'b0;
    rst_n = 1'b0;
    rx_word = '0;
    en_byte_only = 1'b0;
    en_frame_lock = 1'b0;
    do_reset();
    for (int e = 0; e < 10; e++) begin
      run_scn(SCN_TBL[e], e);
    end
    for (int i = 0; i < 6; i++) step(32'h0);
    // R1: after a second reset the offset starts from 0 again (phase fix gives 5)
    do_reset();
    run_scn({5'd5, 1'b1, 1'b0, 5'd5, 2'd1}, 10);
    for (int i = 0; i < 6; i++) step(32'h0);
    for (int e = 0; e < NSCN; e++) begin
      eval_scn(e);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=%0d exp=%0d", n, NSTEP);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule